// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block steps a microprogrammed control unit for a small 32-bit processor. It keeps an 8-bit micro-address register and a 256-entry control store of 44-bit microwords. The control fields of the word at the current micro-address are presented on the outputs every cycle for the datapath to decode.

Each clock edge, the next micro-address is chosen in one of three ways. A dispatch word jumps straight to the handler whose address equals the instruction opcode. A dispatch is suppressed for a conditional branch whose condition fails. Every other word picks one of its two next-address fields, and the choice depends on whether the current instruction uses indirect addressing. Execution starts at the fetch routine at 0x20 after reset, and the register freezes while the run enable is low.

Top module: `useq_top`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) loads the micro-address with 0x20, the first word of the fetch routine, whose word is 44'h010_2108_2121.
- R2: The output word is laid out, MSB first, as micro-op[43:40], bus1[39:36], bus2[35:32], bus3[31:28], alu[27:24], shift[23:20], mem[19:16], nextZero[15:8], nextOne[7:0]. The fetch routine at 0x20..0x23 holds 44'h010_2108_2121, 44'h011_1500_2222, 44'h006_4200_2323 and 44'h100_0000_2020.
- R3: With run high, a word whose micro-op is not 1 moves the micro-address to nextZero when the defer condition is 0.
- R4: The defer condition is ir[31:29]==3'b011 and ir[26]==1. When the condition is 1, a word whose micro-op is not 1 moves the micro-address to nextOne.
- R5: A word with micro-op 1 (dispatch) moves the micro-address to the opcode ir[31:27], zero-extended to 8 bits, unless R6 applies.
- R6: The dispatch is suppressed exactly when the opcode is 0x0F and brOk is 0. The next address then follows R3/R4, and for the fetch dispatch word that address is 0x20.
- R7: While runEn is low, the micro-address does not change.
- R8: In the defer entry at 0x0C, the nextOne target (0x29) is 3 below the nextZero target (0x2C).
- R9: Handler words sit at the opcode addresses. Word 0x00 is 44'h000_0001_2020, word 0x0C is 44'h043_2500_2C29 and word 0x0F is 44'h043_2500_3E3B. Words above 0x3E are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| runEn | input | 1 | Advance enable |
| ir | input | 32 | Instruction register |
| brOk | input | 1 | Branch condition met |
| uAddr | output | 8 | Current micro-address |
| uOp | output | 4 | Micro-op field |
| bus1Src | output | 4 | Bus 1 source code |
| bus2Src | output | 4 | Bus 2 source code |
| bus3Dst | output | 4 | Bus 3 destination code |
| aluSel | output | 4 | ALU function code |
| shiftCtl | output | 4 | Shift control bits |
| memCtl | output | 4 | Memory and run control bits |
| nextZero | output | 8 | Next address when defer condition is 0 |
| nextOne | output | 8 | Next address when defer condition is 1 |

## Verification
Directed walks take the fetch routine into the indirect-load entry two times. The first pass has the indirect bit set and the second has it clear, so the two next-address fields can be told apart. The conditional-branch opcode is dispatched with the condition met and with it failed, which separates a taken dispatch from a suppressed one. A random run drives random instruction words, branch flags and run enable every cycle, with the branch opcode biased upward. Every transition is compared with a model built from the requirements, and each word at a known address is compared with its expected contents.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int FIELD_W = 4;
  localparam int ADDR_W  = 8;
  localparam int WORD_W  = 7 * FIELD_W + 2 * ADDR_W;
  localparam logic [FIELD_W-1:0] UOP_DISPATCH = 4'd1;

  typedef struct packed {
    logic [FIELD_W-1:0] uOp;
    logic [FIELD_W-1:0] bus1;
    logic [FIELD_W-1:0] bus2;
    logic [FIELD_W-1:0] bus3;
    logic [FIELD_W-1:0] alu;
    logic [FIELD_W-1:0] shift;
    logic [FIELD_W-1:0] mem;
    logic [ADDR_W-1:0]  nextZero;
    logic [ADDR_W-1:0]  nextOne;
  } uword_t;

  typedef struct packed {
    logic takeDispatch;
    logic takeAlt;
  } seqStrobe_t;
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output uword_t            word
);
  localparam logic [WORD_W-1:0] NOP = 44'h000_0000_2020;

  function automatic logic [WORD_W-1:0] romInit(input int idx);
    logic [ADDR_W-1:0] k;
    k = idx[ADDR_W-1:0];
    if (idx >= 64) return '0;
    case (k)
      8'h00: return 44'h000_0001_2020;
      8'h01: return 44'h040_3102_2020;
      8'h02: return 44'h043_3700_2020;
      8'h03: return 44'h013_3502_2020;
      8'h08: return 44'h040_8100_2424;
      8'h09: return 44'h003_7200_2525;
      8'h0A: return 44'h052_5500_2626;
      8'h0C: return 44'h043_2500_2C29;
      8'h0D: return 44'h043_2500_322F;
      8'h0E: return 44'h043_2500_3734;
      8'h0F: return 44'h043_2500_3E3B;
      8'h10: return 44'h003_3380_2020;
      8'h11: return 44'h003_3390_2020;
      8'h12: return 44'h003_3300_2020;
      8'h13: return 44'h003_3340_2020;
      8'h14: return 44'h003_3400_2020;
      8'h15: return 44'h033_3500_2020;
      8'h16: return 44'h033_3600_2020;
      8'h17: return 44'h033_3700_2020;
      8'h18: return 44'h033_3800_2020;
      8'h19: return 44'h033_3900_2020;
      8'h20: return 44'h010_2108_2121;
      8'h21: return 44'h011_1500_2222;
      8'h22: return 44'h006_4200_2323;
      8'h23: return 44'h100_0000_2020;
      8'h24: return 44'h007_7200_2020;
      8'h25: return 44'h040_8100_2020;
      8'h26: return 44'h050_2108_2727;
      8'h27: return 44'h000_0000_2828;
      8'h28: return 44'h006_1200_2020;
      8'h29: return 44'h000_0008_2A2A;
      8'h2A: return 44'h000_0000_2B2B;
      8'h2B: return 44'h006_2200_2C2C;
      8'h2C: return 44'h000_0008_2D2D;
      8'h2D: return 44'h000_0000_2E2E;
      8'h2E: return 44'h006_2200_2020;
      8'h2F: return 44'h000_0008_3030;
      8'h30: return 44'h000_0000_3131;
      8'h31: return 44'h006_2200_3232;
      8'h32: return 44'h030_6104_3333;
      8'h33: return 44'h000_0000_2020;
      8'h34: return 44'h000_0008_3535;
      8'h35: return 44'h000_0000_3636;
      8'h36: return 44'h006_2200_3737;
      8'h37: return 44'h010_6100_3838;
      8'h38: return 44'h020_1100_3939;
      8'h39: return 44'h050_2100_3A3A;
      8'h3A: return 44'h051_5500_2020;
      8'h3B: return 44'h000_0008_3C3C;
      8'h3C: return 44'h000_0000_3D3D;
      8'h3D: return 44'h006_2200_3E3E;
      8'h3E: return 44'h020_1100_2020;
      8'h3F: return '0;
      default: return NOP;
    endcase
  endfunction

  logic [WORD_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = romInit(i);
  end

  assign word = uword_t'(rom[addr]);
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int OPC_W = 5,
  parameter logic [OPC_W-1:0] COND_BR_OPC = 5'h0F
) (
  input  logic [FIELD_W-1:0] uOp,
  input  logic [OPC_W-1:0]   opcode,
  input  logic [2:0]         irClass,
  input  logic               indirect,
  input  logic               brOk,
  output seqStrobe_t         strobe
);
  logic dispatchOk;
  logic deferReq;

  always_comb begin
    dispatchOk          = !((opcode == COND_BR_OPC) && !brOk);
    deferReq            = (irClass == 3'b011) && indirect;
    strobe.takeDispatch = (uOp == UOP_DISPATCH) && dispatchOk;
    strobe.takeAlt      = deferReq;
  end
endmodule

// File: rtl/useq_path.sv
module useq_path
  import useq_pkg::*;
#(
  parameter int OPC_W = 5,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              runEn,
  input  seqStrobe_t        strobe,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [ADDR_W-1:0] nextZero,
  input  logic [ADDR_W-1:0] nextOne,
  output logic [ADDR_W-1:0] upc
);
  localparam int PAD_W = ADDR_W - OPC_W;

  logic [ADDR_W-1:0] upcNext;

  always_comb begin
    if (strobe.takeDispatch)  upcNext = {{PAD_W{1'b0}}, opcode};
    else if (strobe.takeAlt)  upcNext = nextOne;
    else                      upcNext = nextZero;
  end

  always_ff @(posedge clk) begin
    if (rst)        upc <= RESET_ADDR;
    else if (runEn) upc <= upcNext;
  end

  a_r1_reset_fetch: assert property (@(posedge clk)
    rst |=> (upc == RESET_ADDR));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !runEn |=> $stable(upc));

  a_r5_dispatch: assert property (@(posedge clk) disable iff (rst)
    (runEn && strobe.takeDispatch) |=> (upc == {{PAD_W{1'b0}}, $past(opcode)}));

  a_r4_alt_target: assert property (@(posedge clk) disable iff (rst)
    (runEn && !strobe.takeDispatch && strobe.takeAlt) |=> (upc == $past(nextOne)));

  a_r3_zero_target: assert property (@(posedge clk) disable iff (rst)
    (runEn && !strobe.takeDispatch && !strobe.takeAlt) |=> (upc == $past(nextZero)));
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int IR_W    = 32,
  parameter int OPC_LSB = 27,
  parameter int OPC_W   = 5,
  parameter int IND_BIT = 26,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 8'h20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               runEn,
  input  logic [IR_W-1:0]    ir,
  input  logic               brOk,
  output logic [ADDR_W-1:0]  uAddr,
  output logic [FIELD_W-1:0] uOp,
  output logic [FIELD_W-1:0] bus1Src,
  output logic [FIELD_W-1:0] bus2Src,
  output logic [FIELD_W-1:0] bus3Dst,
  output logic [FIELD_W-1:0] aluSel,
  output logic [FIELD_W-1:0] shiftCtl,
  output logic [FIELD_W-1:0] memCtl,
  output logic [ADDR_W-1:0]  nextZero,
  output logic [ADDR_W-1:0]  nextOne
);
  uword_t            word;
  seqStrobe_t        strobe;
  logic [ADDR_W-1:0] upc;
  logic [OPC_W-1:0]  opcode;
  logic              unusedIrBits;

  assign opcode       = ir[OPC_LSB +: OPC_W];
  assign unusedIrBits = ^ir[IND_BIT-1:0];

  useq_store u_store (
    .addr (upc),
    .word (word)
  );

  useq_ctrl #(.OPC_W(OPC_W)) u_ctrl (
    .uOp      (word.uOp),
    .opcode   (opcode),
    .irClass  (ir[IR_W-1 -: 3]),
    .indirect (ir[IND_BIT]),
    .brOk     (brOk),
    .strobe   (strobe)
  );

  useq_path #(.OPC_W(OPC_W), .RESET_ADDR(RESET_ADDR)) u_path (
    .clk      (clk),
    .rst      (rst),
    .runEn    (runEn),
    .strobe   (strobe),
    .opcode   (opcode),
    .nextZero (word.nextZero),
    .nextOne  (word.nextOne),
    .upc      (upc)
  );

  assign uAddr    = upc;
  assign uOp      = word.uOp;
  assign bus1Src  = word.bus1;
  assign bus2Src  = word.bus2;
  assign bus3Dst  = word.bus3;
  assign aluSel   = word.alu;
  assign shiftCtl = word.shift;
  assign memCtl   = word.mem;
  assign nextZero = word.nextZero;
  assign nextOne  = word.nextOne;

  a_r6_skip_to_fetch: assert property (@(posedge clk) disable iff (rst)
    (runEn && uAddr == 8'h23 && opcode == 5'h0F && !brOk) |=> (uAddr == RESET_ADDR));

  a_r4_defer_branch: assert property (@(posedge clk) disable iff (rst)
    (runEn && uAddr == 8'h0C && ir[IR_W-1 -: 3] == 3'b011 && ir[IND_BIT]) |=> (uAddr == 8'h29));
endmodule

// File: tb/useq_top_bench.sv
module useq_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        runEn = 1'b1;
  logic [31:0] ir = '0;
  logic        brOk = 1'b1;
  logic [7:0]  uAddr, nextZero, nextOne;
  logic [3:0]  uOp, bus1Src, bus2Src, bus3Dst, aluSel, shiftCtl, memCtl;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  useq_top u_useq_top (
    .clk(clk), .rst(rst), .runEn(runEn), .ir(ir), .brOk(brOk),
    .uAddr(uAddr), .uOp(uOp), .bus1Src(bus1Src), .bus2Src(bus2Src),
    .bus3Dst(bus3Dst), .aluSel(aluSel), .shiftCtl(shiftCtl), .memCtl(memCtl),
    .nextZero(nextZero), .nextOne(nextOne)
  );

  function automatic logic [43:0] curWord();
    return {uOp, bus1Src, bus2Src, bus3Dst, aluSel, shiftCtl, memCtl, nextZero, nextOne};
  endfunction

  function automatic bit knownWord(input logic [7:0] a, output logic [43:0] w);
    case (a)
      8'h00: w = 44'h000_0001_2020;
      8'h0C: w = 44'h043_2500_2C29;
      8'h0F: w = 44'h043_2500_3E3B;
      8'h20: w = 44'h010_2108_2121;
      8'h21: w = 44'h011_1500_2222;
      8'h22: w = 44'h006_4200_2323;
      8'h23: w = 44'h100_0000_2020;
      default: begin w = '0; return 1'b0; end
    endcase
    return 1'b1;
  endfunction

  function automatic logic [7:0] expNext(input logic [3:0] op, input logic [7:0] n0,
      input logic [7:0] n1, input logic [31:0] iv, input bit br, input logic [7:0] cur,
      input bit run);
    bit s1, s2;
    if (!run) return cur;
    s1 = !(iv[31:27] == 5'h0F && !br);
    s2 = (iv[31:29] == 3'b011) && iv[26];
    if (op == 4'd1 && s1) return {3'b000, iv[31:27]};
    return s2 ? n1 : n0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkWord(input string tagFetch);
    logic [43:0] w;
    if (knownWord(uAddr, w))
      check(curWord() == w, (uAddr >= 8'h20) ? tagFetch : "R9 handler word",
            {20'h0, curWord()}, {20'h0, w});
  endtask

  // Drive one cycle at a falling edge, check the address at the next falling edge.
  task automatic step(input logic [31:0] iv, input bit br, input bit run);
    logic [7:0] e;
    string tag;
    e = expNext(uOp, nextZero, nextOne, iv, br, uAddr, run);
    if (!run) tag = "R7 hold";
    else if (uOp == 4'd1 && !(iv[31:27] == 5'h0F && !br)) tag = "R5 dispatch";
    else if (uOp == 4'd1) tag = "R6 suppressed dispatch";
    else if (iv[31:29] == 3'b011 && iv[26]) tag = "R4 defer target";
    else tag = "R3 plain target";
    ir = iv; brOk = br; runEn = run;
    @(negedge clk);
    check(uAddr == e, tag, {56'h0, uAddr}, {56'h0, e});
    checkWord("R2 fetch word");
  endtask

  task automatic goTo23();
    for (int i = 0; i < 16 && uAddr != 8'h23; i++) step(32'h0, 1'b1, 1'b1);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        miscompares++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] hold;
    repeat (2) @(negedge clk);
    check(uAddr == 8'h20, "R1 reset address", {56'h0, uAddr}, 64'h20);
    check(curWord() == 44'h010_2108_2121, "R1 reset word", {20'h0, curWord()}, 64'h010_2108_2121);
    rst = 1'b0;

    // Fetch walk with word checks (R2), then indirect LDR entry (R5, R8)
    step(32'h0, 1'b1, 1'b1);
    step(32'h0, 1'b1, 1'b1);
    step(32'h0, 1'b1, 1'b1);
    step({5'h0C, 1'b1, 26'h0}, 1'b1, 1'b1);
    check(uAddr == 8'h0C, "R5 dispatch to 0x0C", {56'h0, uAddr}, 64'h0C);
    check(nextZero - nextOne == 8'd3, "R8 defer spacing", {56'h0, nextZero - nextOne}, 64'd3);
    step({5'h0C, 1'b1, 26'h0}, 1'b1, 1'b1);
    check(uAddr == 8'h29, "R8 indirect target", {56'h0, uAddr}, 64'h29);

    goTo23();
    step({5'h0C, 1'b0, 26'h0}, 1'b1, 1'b1);
    step({5'h0C, 1'b0, 26'h0}, 1'b1, 1'b1);
    check(uAddr == 8'h2C, "R8 direct target", {56'h0, uAddr}, 64'h2C);

    goTo23();
    step({5'h0F, 1'b1, 26'h0}, 1'b0, 1'b1);
    check(uAddr == 8'h20, "R6 branch not met goes to fetch", {56'h0, uAddr}, 64'h20);

    goTo23();
    step({5'h0F, 1'b0, 26'h0}, 1'b1, 1'b1);
    check(uAddr == 8'h0F, "R5 branch met dispatches", {56'h0, uAddr}, 64'h0F);
    step({5'h0F, 1'b0, 26'h0}, 1'b1, 1'b1);
    check(uAddr == 8'h3E, "R3 direct branch target", {56'h0, uAddr}, 64'h3E);

    goTo23();
    hold = uAddr;
    for (int i = 0; i < 3; i++) step({5'h0C, 1'b1, 26'h0}, 1'b1, 1'b0);
    check(uAddr == hold, "R7 dispatch held", {56'h0, uAddr}, {56'h0, hold});

    // Dispatch every opcode once and check the handler words seen (R9)
    for (int op = 0; op < 32; op++) begin
      goTo23();
      step({op[4:0], 27'h0}, 1'b1, 1'b1);
    end

    // Constrained random run
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] iv;
      iv = $urandom;
      if ($urandom_range(0, 3) == 0) iv[31:27] = 5'h0F;
      step(iv, bit'($urandom_range(0, 1)), $urandom_range(0, 7) != 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule